// File: doc/BRIEF.md
# Command Completion Signal Monitor

This block guards a shared, open-drain style command line after the host has launched a command that asks the card to signal completion. It tracks the pending state, watches the sampled line for the card's completion signal, refuses ordinary commands while the signal is outstanding, and transmits a fixed completion-disable token when asked. It reports the result through two single-cycle interrupt pulses: one when the card's completion signal is seen, and one when a disable token has finished.

The card's signal and the host's token pull the line to the same level. When the two overlap, the block treats it as a normal case and raises no error. The timing of the card's signal relative to the token decides which interrupts fire. A signal seen before the token starts gives both pulses. A signal that falls inside the token, or that never comes, gives only the done pulse. A signal with no disable request gives only the signal pulse.

Top module: `ccs_line_guard`

## Requirements
- R1: During reset and after it, `cmd_allowed` is 1, `cmd_line_oe` is 0, `cmd_line_o` is 1, and both interrupt outputs are 0.
- R2: After `cs_launch` is accepted in idle, `cmd_allowed` is 0 and `cmd_grant` stays 0 for any `cmd_req` until the pending state ends.
- R3: A disable request accepted at a clock edge makes the block drive the token on the next five cycles with `cmd_line_oe` high. The token is the bit order 0,0,0,0,1, most significant first, one bit per cycle. The line is then released.
- R4: `irq_done` pulses for exactly one cycle, in the cycle after the last token bit. In that cycle `cmd_allowed` is 1, so `cmd_grant` follows `cmd_req` and an abort command can be issued.
- R5: In the pending state with no disable request, a low sample on `cmd_line_i` gives exactly one `irq_sig` pulse in the next cycle and returns the block to idle. No token is sent.
- R6: A low level on `cmd_line_i` while the token is being driven raises no `irq_sig`.
- R7: If the completion signal was seen before the disable request, a later `cs_disable_req` in idle still sends the full token, followed by `irq_done`.
- R8: A low level on `cmd_line_i` outside the pending state raises no `irq_sig`.
- R9: If a low line sample and `cs_disable_req` come in the same pending cycle, `irq_sig` pulses and the token is sent, followed by `irq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_launch | input | 1 | Strobe: a command that requests a completion signal was launched |
| cs_disable_req | input | 1 | Request to send the completion-disable token |
| cmd_req | input | 1 | Generic command request |
| cmd_line_i | input | 1 | Sampled command line level |
| cmd_line_o | output | 1 | Level driven onto the command line |
| cmd_line_oe | output | 1 | Drive enable for the command line |
| cmd_allowed | output | 1 | High when a generic command may start |
| cmd_grant | output | 1 | `cmd_req` qualified by `cmd_allowed` |
| irq_sig | output | 1 | One-cycle pulse: completion signal detected |
| irq_done | output | 1 | One-cycle pulse: disable token finished |

## Verification
The line is pulled low at four different moments relative to the disable request. The first is alone in the pending state, which tells the signal-only outcome apart from the others. The second is before the request, which should give both pulses in order. The third is in the same cycle as the request, which checks the priority of detection over the token start. The fourth is during the token, where the signal must be masked. A clean disable with the line held high separates the token bit order and its timing from any effect of detection. Low levels in idle show that detection is gated on the pending state.

// File: rtl/ccsm_pkg.sv
package ccsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SEND = 2'd2
  } ccsm_state_e;
endpackage

// File: rtl/ccsm_token_tx.sv
module ccsm_token_tx #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] PATTERN = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last,
  output logic tok_bit
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] IDX_LAST = CW'(W - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          busy_nxt;
  logic          cnt_en;

  assign cnt_en = busy | start;
  assign last   = busy & (cnt == IDX_LAST);

  always_comb begin
    cnt_nxt  = cnt;
    busy_nxt = busy;
    if (busy) begin
      if (cnt == IDX_LAST) begin
        busy_nxt = 1'b0;
        cnt_nxt  = '0;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end else if (start) begin
      busy_nxt = 1'b1;
      cnt_nxt  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cnt_en) begin
      busy <= busy_nxt;
      cnt  <= cnt_nxt;
    end
  end

  always_comb begin
    tok_bit = busy ? PATTERN[IDX_LAST - cnt] : 1'b1;
  end

  // R3: once started, the token runs without a gap until its last bit
  assert_token_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  // R3: the line is released right after the last bit
  assert_token_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/ccsm_ctrl.sv
module ccsm_ctrl
  import ccsm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic dis_req,
  input  logic line_i,
  input  logic tx_busy,
  input  logic tx_last,
  output logic tx_start,
  output logic pending,
  output logic allowed,
  output logic irq_sig,
  output logic irq_done
);
  ccsm_state_e state, state_nxt;
  logic        sig_nxt, done_nxt;

  always_comb begin
    state_nxt = state;
    sig_nxt   = 1'b0;
    done_nxt  = 1'b0;
    tx_start  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (dis_req) begin
          state_nxt = ST_SEND;
          tx_start  = 1'b1;
        end else if (launch) begin
          state_nxt = ST_PEND;
        end
      end
      ST_PEND: begin
        if (!line_i) sig_nxt = 1'b1;
        if (dis_req) begin
          state_nxt = ST_SEND;
          tx_start  = 1'b1;
        end else if (!line_i) begin
          state_nxt = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (tx_last) begin
          state_nxt = ST_IDLE;
          done_nxt  = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      irq_sig  <= 1'b0;
      irq_done <= 1'b0;
    end else begin
      state    <= state_nxt;
      irq_sig  <= sig_nxt;
      irq_done <= done_nxt;
    end
  end

  assign pending = (state == ST_PEND);
  assign allowed = (state == ST_IDLE);

  // R3: the sending state and the token shifter agree
  assert_send_matches_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) == tx_busy);
  // R4: the end of the token produces the done pulse
  assert_done_after_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> (irq_done && state == ST_IDLE));
  // R6: no signal interrupt comes from the sending state
  assert_no_sig_in_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) |=> !irq_sig);
  // R5: the signal interrupt lasts one cycle
  assert_sig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sig |=> !irq_sig);
  // R4: the done interrupt lasts one cycle
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
endmodule

// File: rtl/ccs_line_guard.sv
module ccs_line_guard #(
  parameter int unsigned TOKEN_W = 5,
  parameter logic [TOKEN_W-1:0] TOKEN_BITS = 5'b00001,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_launch,
  input  logic cs_disable_req,
  input  logic cmd_req,
  input  logic cmd_line_i,
  output logic cmd_line_o,
  output logic cmd_line_oe,
  output logic cmd_allowed,
  output logic cmd_grant,
  output logic irq_sig,
  output logic irq_done
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_n_i;
  logic tx_start, tx_busy, tx_last, tx_bit, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_i = rst_pipe[SYNC_STAGES-1];

  ccsm_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .launch   (cs_launch),
    .dis_req  (cs_disable_req),
    .line_i   (cmd_line_i),
    .tx_busy  (tx_busy),
    .tx_last  (tx_last),
    .tx_start (tx_start),
    .pending  (pending),
    .allowed  (cmd_allowed),
    .irq_sig  (irq_sig),
    .irq_done (irq_done)
  );

  ccsm_token_tx #(
    .W       (TOKEN_W),
    .PATTERN (TOKEN_BITS)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (tx_start),
    .busy    (tx_busy),
    .last    (tx_last),
    .tok_bit (tx_bit)
  );

  assign cmd_line_oe = tx_busy;
  assign cmd_line_o  = tx_bit;
  assign cmd_grant   = cmd_req & cmd_allowed;

  // R2: no generic command passes while completion is pending
  assert_block_pending_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    pending |-> !cmd_grant);
  // R1: the line is released whenever no token is being sent
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cmd_line_oe |-> cmd_line_o);
endmodule

// File: tb/ccs_line_guard_tb.sv
module ccs_line_guard_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [4:0] C_SIG  = 5'd1;
  localparam logic [4:0] C_DONE = 5'd2;
  localparam logic [4:0] C_BIT0 = 5'd16;
  localparam logic [4:0] C_BIT1 = 5'd17;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_launch, cs_disable_req, cmd_req, cmd_line_i;
  logic cmd_line_o, cmd_line_oe, cmd_allowed, cmd_grant, irq_sig, irq_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccs_line_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cs_launch(cs_launch), .cs_disable_req(cs_disable_req),
    .cmd_req(cmd_req), .cmd_line_i(cmd_line_i), .cmd_line_o(cmd_line_o),
    .cmd_line_oe(cmd_line_oe), .cmd_allowed(cmd_allowed), .cmd_grant(cmd_grant),
    .irq_sig(irq_sig), .irq_done(irq_done)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic push_token(input string tag);
    push(C_BIT0, tag); push(C_BIT0, tag); push(C_BIT0, tag); push(C_BIT0, tag);
    push(C_BIT1, tag);
  endtask

  task automatic compare(input logic [4:0] got);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected-event actual=%0d expected=none", got);
    end else begin
      logic [4:0] e = exp_q.pop_front();
      string      t = tag_q.pop_front();
      if (e !== got) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", t, got, e);
      end
    end
  endtask

  // monitor: compare every observed event against the expected queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (irq_sig === 1'b1) compare(C_SIG);
      if (cmd_line_oe === 1'b1) compare(cmd_line_o ? C_BIT1 : C_BIT0);
      if (irq_done === 1'b1) compare(C_DONE);
    end
  end

  task automatic cyc(input logic l, input logic d, input logic c, input logic ln);
    @(negedge clk);
    #1;
    cs_launch = l; cs_disable_req = d; cmd_req = c; cmd_line_i = ln;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_launch = 1'b0; cs_disable_req = 1'b0; cmd_req = 1'b0; cmd_line_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 allowed in reset", 8'(cmd_allowed), 8'd1);
    check("R1 oe in reset", 8'(cmd_line_oe), 8'd0);
    check("R1 line level in reset", 8'(cmd_line_o), 8'd1);
    check("R1 irqs in reset", {6'd0, irq_sig, irq_done}, 8'd0);
    rst_n = 1'b1;
    idle(4);
    check("R1 allowed after reset", 8'(cmd_allowed), 8'd1);
    mon_on = 1'b1;

    // R8: low line in idle is ignored
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 no signal irq in idle", 8'(irq_sig), 8'd0);
    idle(2);

    // R5 + R2: signal alone while pending
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    check("R2 allowed while pending", 8'(cmd_allowed), 8'd0);
    check("R2 grant while pending", 8'(cmd_grant), 8'd0);
    push(C_SIG, "R5 signal only");
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    check("R5 back to idle", 8'(cmd_grant), 8'd1);
    idle(3);

    // R3 + R4: clean disable with line high
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    push_token("R3 token bits");
    push(C_DONE, "R4 done after token");
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    check("R3 oe during token", 8'(cmd_line_oe), 8'd1);
    check("R2 grant during token", 8'(cmd_grant), 8'd0);
    idle(4);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    check("R4 done pulse cycle", 8'(irq_done), 8'd1);
    check("R4 abort allowed", 8'(cmd_grant), 8'd1);
    idle(1);
    check("R4 done single cycle", 8'(irq_done), 8'd0);
    check("R3 line released", 8'(cmd_line_oe), 8'd0);
    idle(2);

    // R6: signal during the token is masked
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    push_token("R6 token bits");
    push(C_DONE, "R6 done only");
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 no signal irq", 8'(irq_sig), 8'd0);
    idle(3);

    // R7: signal before the disable request
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    push(C_SIG, "R7 signal first");
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    push_token("R7 token bits");
    push(C_DONE, "R7 done after token");
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    idle(8);

    // R9: signal and disable in the same pending cycle
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    push(C_SIG, "R9 signal same cycle");
    push_token("R9 token bits");
    push(C_DONE, "R9 done after token");
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    idle(8);

    check("R3 all expected events seen", 8'(exp_q.size()), 8'd0);
    mon_on = 1'b0;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule